// File: doc/BRIEF.md
# Serial-Input Latched Sink Driver

This block converts a serial bit stream into a 32-channel parallel drive word for banks of current sinks, such as print-head dots, multiplexed LED rows or lamps. A host shifts data in on the rising edges of a shift clock. It then raises a strobe, which copies the whole shift path into a latch bank. An active-high output enable either passes the latch bank to the channel drives or blanks every channel at once. A serial output carries the last shift stage, so several blocks can be chained on one data line.

The shift path is built from equal segments chained end to end, two 16-bit segments by default. The host-side shift clock, data and strobe are sampled by the block's own clock through a short synchronizer. A rising shift-clock edge is detected in that domain. For as long as the strobe is held high, the latch bank follows the shift path on every system clock cycle. The enable gates the drives combinationally and never writes the latch bank. Minimum host timing (data setup and hold, shift-clock high width, shift-clock-to-strobe gap, strobe width) is given in system clock cycles. Assertions inside the block check that timing.

Top module: `serial_sink_driver`

## Requirements
- R1: While `rst_n` is low, the shift path and the latch bank are cleared, so `sink_on` is all zero and `ser_out` is 0.
- R2: On each rising edge of `shift_clk`, `ser_in` enters stage 1 and every stage moves one place toward `ser_out`. Channel k is driven on `sink_on[k-1]`. After CHANNELS rising edges, the first bit shifted is latched onto `sink_on[CHANNELS-1]` and the last bit onto `sink_on[0]`.
- R3: `ser_out` equals the last shift stage. It changes within SYNC_STAGES+1 clock cycles of a `shift_clk` rising edge and repeats the bit shifted in CHANNELS edges earlier.
- R4: While `strobe` is low, the latch bank holds its contents, so shifting does not change `sink_on`.
- R5: While `strobe` is high, the latch bank follows the shift path and keeps following each new shift until `strobe` falls.
- R6: With `out_en` low, every bit of `sink_on` is 0. With `out_en` high, `sink_on` equals the latch bank.
- R7: `out_en` does not alter the latch bank. Data stored or loaded while the outputs are blanked reappears unchanged when `out_en` returns high.
- R8: Exactly one shift happens per rising edge of `shift_clk`. Holding `shift_clk` high and then lowering it moves no data.
- R9: Two blocks chained from `ser_out` into `ser_in` behave as one 2×CHANNELS shift path. After 2×CHANNELS edges, the downstream block holds the first CHANNELS bits and the upstream block holds the last CHANNELS bits.
- R10: Host timing, counted in clock cycles: `ser_in` stable SETUP_CYC cycles before and HOLD_CYC cycles after a `shift_clk` rise; `shift_clk` high for at least SCLK_HI_CYC cycles; `strobe` rising at least SCLK_TO_STB_CYC cycles after a `shift_clk` rise; `strobe` high for at least STB_HI_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host interface |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data from the host or the previous block |
| shift_clk | input | 1 | Shift clock; data moves on its rising edge |
| strobe | input | 1 | Level-sensitive latch load; transparent while high |
| out_en | input | 1 | Active-high enable; low blanks all channels |
| ser_out | output | 1 | Last shift stage, for chaining |
| sink_on | output | CHANNELS | Channel drives; 1 turns the sink on |

## Verification
A wrong bit in the shift path shows on `ser_out` only after it has been moved to the end of the path, up to CHANNELS shift edges later. On `sink_on` it shows only after the next strobe. A latch bank that follows the shift path while it should hold changes `sink_on` within a few cycles of the next shift edge. A latch bank that fails to follow the strobe shows a stale word as soon as the strobe settles. The checks therefore cover `ser_out` after every comparison point and `sink_on` both across strobes and between them. A chained pair of blocks exposes errors in order or latency at the segment joins.

// File: rtl/serial_sink_driver.sv
module serial_sink_driver #(
  parameter int CHANNELS        = 32,
  parameter int SEGMENTS        = 2,
  parameter int SYNC_STAGES     = 2,
  parameter int SETUP_CYC       = 4,
  parameter int HOLD_CYC        = 4,
  parameter int SCLK_HI_CYC     = 7,
  parameter int SCLK_TO_STB_CYC = 13,
  parameter int STB_HI_CYC      = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                shift_clk,
  input  logic                strobe,
  input  logic                out_en,
  output logic                ser_out,
  output logic [CHANNELS-1:0] sink_on
);
  localparam int SEG_LEN = CHANNELS / SEGMENTS;
  localparam int CW = 8;
  localparam logic [CW-1:0] SAT = '1;

  logic [SYNC_STAGES-1:0] sclk_pipe, din_pipe, stb_pipe;
  logic sclk_s, din_s, stb_s, sclk_last, step;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_pipe <= '0;
      din_pipe  <= '0;
      stb_pipe  <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], shift_clk};
      din_pipe  <= {din_pipe[SYNC_STAGES-2:0], ser_in};
      stb_pipe  <= {stb_pipe[SYNC_STAGES-2:0], strobe};
      sclk_last <= sclk_s;
    end

  assign sclk_s = sclk_pipe[SYNC_STAGES-1];
  assign din_s  = din_pipe[SYNC_STAGES-1];
  assign stb_s  = stb_pipe[SYNC_STAGES-1];
  assign step   = sclk_s & ~sclk_last;

  logic [CHANNELS-1:0] stage;

  for (genvar g = 0; g < SEGMENTS; g++) begin : g_seg
    logic [SEG_LEN-1:0] q;
    logic feed;
    if (g == 0) begin : g_head
      assign feed = din_s;
    end else begin : g_link
      assign feed = stage[g*SEG_LEN-1];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    q <= '0;
      else if (step) q <= {q[SEG_LEN-2:0], feed};
    assign stage[g*SEG_LEN +: SEG_LEN] = q;
  end

  logic [CHANNELS-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     latch_q <= '0;
    else if (stb_s) latch_q <= stage;

  assign ser_out = stage[CHANNELS-1];
  assign sink_on = latch_q & {CHANNELS{out_en}};

  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> stage[0] == $past(din_s));
  p_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ser_out == $past(stage[CHANNELS-2]));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s |=> $stable(latch_q));
  p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> latch_q == $past(stage));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(stage));

  logic sclk_r, din_r, stb_r;
  logic [CW-1:0] since_rise, din_age, stb_age;
  logic rise_raw, fall_raw, din_chg, stb_rise, stb_fall;

  assign rise_raw = shift_clk & ~sclk_r;
  assign fall_raw = ~shift_clk & sclk_r;
  assign din_chg  = ser_in ^ din_r;
  assign stb_rise = strobe & ~stb_r;
  assign stb_fall = ~strobe & stb_r;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_r <= 1'b0; din_r <= 1'b0; stb_r <= 1'b0;
      since_rise <= SAT; din_age <= SAT; stb_age <= SAT;
    end else begin
      sclk_r     <= shift_clk;
      din_r      <= ser_in;
      stb_r      <= strobe;
      since_rise <= rise_raw ? '0 : bump(since_rise);
      din_age    <= din_chg  ? '0 : bump(din_age);
      stb_age    <= stb_rise ? '0 : bump(stb_age);
    end

  p_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_raw |-> (!din_chg && din_age >= CW'(SETUP_CYC)));
  p_din_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    din_chg |-> (!rise_raw && since_rise >= CW'(HOLD_CYC)));
  p_sclk_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_raw |-> since_rise >= CW'(SCLK_HI_CYC - 1));
  p_clk_to_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |-> since_rise >= CW'(SCLK_TO_STB_CYC));
  p_stb_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |-> stb_age >= CW'(STB_HI_CYC - 1));
endmodule

// File: tb/serial_sink_driver_bench.sv
module serial_sink_driver_bench;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, sclk = 1'b0, stb = 1'b0, oe = 1'b1;
  logic sdo1, sdo2;
  logic [N-1:0] drv1, drv2;

  always #4 clk = ~clk;

  serial_sink_driver u_serial_sink_driver (
    .clk(clk), .rst_n(rst_n), .ser_in(sdi), .shift_clk(sclk), .strobe(stb),
    .out_en(oe), .ser_out(sdo1), .sink_on(drv1));

  // R9: downstream block; its data edge trails the shift edge by 3 cycles
  serial_sink_driver #(.HOLD_CYC(2)) u_chain (
    .clk(clk), .rst_n(rst_n), .ser_in(sdo1), .shift_clk(sclk), .strobe(stb),
    .out_en(oe), .ser_out(sdo2), .sink_on(drv2));

  typedef struct {
    logic [N-1:0] d1, d2;
    logic s1, s2;
    string tag;
  } item_t;

  item_t exp_q[$];
  int pending = 0;
  int checks = 0, fails = 0;
  logic [N-1:0] m_sr1 = '0, m_sr2 = '0, m_l1 = '0, m_l2 = '0;

  task automatic expect_now(input string tag);
    item_t it;
    it.d1 = oe ? m_l1 : '0;
    it.d2 = oe ? m_l2 : '0;
    it.s1 = m_sr1[N-1];
    it.s2 = m_sr2[N-1];
    it.tag = tag;
    exp_q.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  initial begin
    forever begin
      item_t it;
      wait (pending > 0);
      repeat (6) @(negedge clk);
      it = exp_q[0];
      checks++;
      if (drv1 !== it.d1 || drv2 !== it.d2 || sdo1 !== it.s1 || sdo2 !== it.s2) begin
        fails++;
        $display("FAIL %s drv=%h/%h sdo=%b/%b expected drv=%h/%h sdo=%b/%b",
                 it.tag, drv1, drv2, sdo1, sdo2, it.d1, it.d2, it.s1, it.s2);
      end
      void'(exp_q.pop_front());
      pending--;
    end
  end

  // R10 host timing observed on the driven pins
  int cyc = 0, t_din = 0, t_rise = -1000, viol = 0;
  logic sclk_p = 1'b0, sdi_p = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (sdi !== sdi_p) begin
      if (cyc - t_rise < 4) viol++;
      t_din = cyc;
    end
    if (sclk && !sclk_p) begin
      if (cyc - t_din < 4) viol++;
      t_rise = cyc;
    end
    sclk_p = sclk;
    sdi_p = sdi;
  end

  task automatic put_bit(input logic b);
    @(negedge clk) sdi = b;
    m_sr2 = {m_sr2[N-2:0], m_sr1[N-1]};
    m_sr1 = {m_sr1[N-2:0], b};
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    if (stb) begin m_l1 = m_sr1; m_l2 = m_sr2; end
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic put_word(input logic [N-1:0] w, input int every, input string tag);
    for (int i = N - 1; i >= 0; i--) begin
      put_bit(w[i]);
      if (i % every == 0) expect_now(tag);
    end
  endtask

  task automatic pulse_stb();
    repeat (14) @(negedge clk);
    stb = 1'b1;
    m_l1 = m_sr1; m_l2 = m_sr2;
    repeat (8) @(negedge clk);
    stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  localparam logic [N-1:0] P = 32'hA5C3_0F96;
  localparam logic [N-1:0] Q = 32'h1234_8001;

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 reset clears outputs");
    rst_n = 1'b1;

    put_word(P, 8, "R4 shift with strobe low leaves drive, R3 ser_out");
    pulse_stb();
    expect_now("R2 first bit on top channel");
    checks++;
    if (drv1 !== P) begin
      fails++;
      $display("FAIL R2 word order drv=%h expected=%h", drv1, P);
    end

    put_word(Q, 4, "R4 hold during reshift, R3 ser_out repeats old word");
    pulse_stb();
    expect_now("R9 chained pair holds both words");

    @(negedge clk) oe = 1'b0;
    expect_now("R6 blank forces all channels off");
    @(negedge clk) oe = 1'b1;
    expect_now("R7 latch unchanged by blanking");
    @(negedge clk) oe = 1'b0;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    pulse_stb();
    expect_now("R6 blanked during load");
    @(negedge clk) oe = 1'b1;
    expect_now("R7 load while blanked appears");

    repeat (14) @(negedge clk);
    stb = 1'b1;
    m_l1 = m_sr1; m_l2 = m_sr2;
    for (int i = 0; i < 8; i++) begin
      put_bit(i[0] ^ i[2]);
      expect_now("R5 transparent latch follows shift");
    end

    @(negedge clk) sdi = ~m_sr1[0];
    m_sr2 = {m_sr2[N-2:0], m_sr1[N-1]};
    m_sr1 = {m_sr1[N-2:0], sdi};
    m_l1 = m_sr1; m_l2 = m_sr2;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    expect_now("R8 one shift on rising edge");
    repeat (30) @(negedge clk);
    expect_now("R8 no shift while clock held high");
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    expect_now("R8 no shift on falling edge");
    repeat (14) @(negedge clk);
    stb = 1'b0;
    repeat (4) @(negedge clk);

    rst_n = 1'b0;
    m_sr1 = '0; m_sr2 = '0; m_l1 = '0; m_l2 = '0;
    expect_now("R1 reset mid-run clears all");
    rst_n = 1'b1;

    checks++;
    if (viol != 0) begin
      fails++;
      $display("FAIL R10 host timing violations=%0d expected=0", viol);
    end
    finish_up();
  end
endmodule